// File: doc/BRIEF.md
# Reloadable Timer with Prescaler

This block is a general-purpose down-counting timer for a control-oriented DSP subsystem. An 8-bit prescaler counts down the system clock and reloads itself each time it reaches zero. Every reload flips a divide-by-two flip-flop, and the output of that flip-flop is the timer clock, which has an exact 50 percent duty cycle. A 16-bit main counter steps down once on each rising edge of the timer clock. When a step finds the counter already at zero, the counter reloads from its load register instead. That reload event sets a sticky interrupt flag, if the interrupt is enabled. In output mode it also produces a one-cycle timeout pulse.

Software drives the block through a small synchronous register port. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the address is presented. The prescaler reload register stores a full data word, but only its low byte is used. The live count can be read back at any time.

Top module: `reload_timer`

## Requirements
- R1: After reset, the count, load value, prescaler register, control bits, interrupt flag, read data, timer clock and timeout pulse are all zero.
- R2: While running, the timer clock toggles once every P+1 system cycles, so it is high for P+1 cycles and low for P+1 cycles. P is bits [7:0] of the prescaler register (address 2), and bits [15:8] of that register have no effect on timing.
- R3: The run bit is control bit 0 at address 0. While it is set, the count steps down once per rising edge of the timer clock. The first rising edge comes P+1 cycles after the edge that sets run. While run is clear, the count holds and the timer clock stays low.
- R4: A step taken at count zero reloads the count from the load register (address 1). With a count L at start, the first reload occurs P+1+2L(P+1) cycles after run is set. Later reloads repeat every 2(L+1)(P+1) cycles.
- R5: A write to the load register while stopped also sets the count at once. A write while running changes only the value used at the next reload.
- R6: The interrupt enable is control bit 1. A reload with the enable set sets the interrupt flag, and the flag stays set until a write to address 3 with data bit 0 equal to 1 clears it. With the enable clear, a reload leaves the flag alone.
- R7: The mode bit is control bit 2, where 1 selects output mode and 0 selects input mode. In output mode, each reload produces a one-cycle high on the timeout output in the cycle after the reload edge. In input mode, the timeout output stays low.
- R8: The read data is registered: one cycle after an address is presented, the read data shows that register's value. Address 0 returns the control bits in bits [2:0] and the interrupt flag in bit 15. Address 1 returns the load value, address 2 the full prescaler register, and address 3 the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Sticky interrupt request |
| tmo_o | output | 1 | One-cycle timeout pulse on reload (output mode) |
| tclk_o | output | 1 | Timer clock, 50 percent duty |

## Verification
The bench builds the block with its default widths: a 16-bit count, an 8-bit prescaler and a 16-bit data word. These widths bring several cases within reach of a short run:
- A prescale of zero, which gives the fastest timer clock.
- A prescale of two, used to measure the duty cycle.
- A prescale of 255, which leaves a 256-cycle window in which a load written while running must not reach the count.
- A prescaler register with nonzero upper bits, which shows that the upper byte is ignored.

Small load values keep several reload periods inside a few dozen cycles. This lets the scoreboard match the cycle of each timeout pulse against the period formula.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_LOAD = 2'd1,
    A_PRE  = 2'd2,
    A_CNT  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic mode_out;
    logic irq_en;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic             tclk_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic             tclk_q;
  logic             at_zero;

  assign at_zero = (pcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      tclk_q <= 1'b0;
    end else if (!run_i) begin
      pcnt_q <= reload_i;
      tclk_q <= 1'b0;
    end else if (at_zero) begin
      pcnt_q <= reload_i;
      tclk_q <= ~tclk_q;
    end else begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  // rising edge of the timer clock happens at the next edge
  assign tick_o = run_i && at_zero && !tclk_q;
  assign tclk_o = tclk_q;

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tclk_q);
  assert_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (run_i && at_zero) |=> (tclk_q != $past(tclk_q)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (run_i && !at_zero) |=> ($stable(tclk_q) && pcnt_q == $past(pcnt_q) - 1'b1));
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             ld_now_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             mode_out_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tmo_q;

  assign reload_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      tmo_q <= reload_o && mode_out_i;
      if (ld_now_i)
        cnt_q <= ld_val_i;
      else if (tick_i)
        cnt_q <= reload_o ? load_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign tmo_o = tmo_q;

  assert_reload_val_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q == '0 && !ld_now_i) |=> (cnt_q == $past(load_i)));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q != '0 && !ld_now_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !ld_now_i) |=> $stable(cnt_q));
  assert_pulse_out_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q == '0 && mode_out_i) |=> tmo_q);
  assert_pulse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_out_i |=> !tmo_q);
endmodule

// File: rtl/rtmr_regs.sv
module rtmr_regs
  import rtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              reload_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [DATA_W-1:0] pre_o,
  output logic              ld_now_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned FLAG_BIT = DATA_W - 1;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] pre_q;
  logic              flag_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_next;
  logic              clr_req;
  logic              set_req;

  assign clr_req  = we_i && (reg_addr_e'(addr_i) == A_CNT) && wdata_i[0];
  assign set_req  = reload_i && ctrl_q.irq_en;
  assign ld_now_o = we_i && (reg_addr_e'(addr_i) == A_LOAD) && !ctrl_q.run;

  always_comb begin
    rd_next = '0;
    case (reg_addr_e'(addr_i))
      A_CTRL: begin
        rd_next[CTRL_W-1:0] = ctrl_q;
        rd_next[FLAG_BIT]   = flag_q;
      end
      A_LOAD:  rd_next = DATA_W'(load_q);
      A_PRE:   rd_next = pre_q;
      default: rd_next = DATA_W'(cnt_i);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      pre_q   <= '0;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
      if (we_i) begin
        case (reg_addr_e'(addr_i))
          A_CTRL:  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          A_LOAD:  load_q <= wdata_i[CNT_W-1:0];
          A_PRE:   pre_q  <= wdata_i;
          default: ;
        endcase
      end
      if (set_req)
        flag_q <= 1'b1;
      else if (clr_req)
        flag_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign pre_o   = pre_q;
  assign irq_o   = flag_q;
  assign rdata_o = rdata_q;

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
    (reload_i && ctrl_q.irq_en) |=> flag_q);
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(we_i && addr_i == 2'd3 && wdata_i[0])) |=> flag_q);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(reload_i && ctrl_q.irq_en)) |=> !flag_q);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              tmo_o,
  output logic              tclk_o
);
  import rtmr_pkg::*;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  load_val;
  logic [DATA_W-1:0] pre_val;
  logic              ld_now;
  logic [CNT_W-1:0]  cnt;
  logic              reload;
  logic              tick;

  rtmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .cnt_i    (cnt),
    .reload_i (reload),
    .ctrl_o   (ctrl),
    .load_o   (load_val),
    .pre_o    (pre_val),
    .ld_now_o (ld_now),
    .irq_o    (irq_o),
    .rdata_o  (bus_rdata)
  );

  rtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run_i    (ctrl.run),
    .reload_i (pre_val[PRE_W-1:0]),
    .tclk_o   (tclk_o),
    .tick_o   (tick)
  );

  rtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .load_i     (load_val),
    .ld_now_i   (ld_now),
    .ld_val_i   (bus_wdata[CNT_W-1:0]),
    .mode_out_i (ctrl.mode_out),
    .cnt_o      (cnt),
    .reload_o   (reload),
    .tmo_o      (tmo_o)
  );
endmodule

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, tmo_o, tclk_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_c0 = 0;
  int exp_q[$];

  reload_timer i_reload_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .tmo_o(tmo_o), .tclk_o(tclk_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each timeout pulse is matched against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && tmo_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected pulse", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 pulse cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    last_c0 = cyc + 1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // driver: push the cycles at which reload pulses must appear
  task automatic expect_pulses(input int c0, input int p, input int l, input int n);
    for (int k = 0; k < n; k++)
      exp_q.push_back(c0 + p + 1 + 2*l*(p+1) + k*2*(l+1)*(p+1));
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int c0, hi, lo;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(bus_rdata == 0 && irq_o == 0 && tmo_o == 0 && tclk_o == 0, "R1 outputs",
          {irq_o, tmo_o, tclk_o}, 0);
    rd(2'd3, v); check(v == 0, "R1 count", v, 0);
    rd(2'd0, v); check(v == 0, "R1 ctrl", v, 0);

    // R5 load while stopped, R8 readback
    wr(2'd1, 16'd5);
    rd(2'd3, v); check(v == 5, "R5 immediate load", v, 5);
    rd(2'd1, v); check(v == 5, "R8 load readback", v, 5);
    wr(2'd2, 16'hAB00);
    rd(2'd2, v); check(v == 16'hAB00, "R8 prescaler readback", v, 16'hAB00);

    // R4/R7 output mode, P=0 (upper byte ignored, R2), L=5
    wr(2'd0, 16'h0007);
    c0 = last_c0;
    expect_pulses(c0, 0, 5, 3);
    repeat (40) @(negedge clk);
    wr(2'd0, 16'h0000);
    repeat (15) @(negedge clk);
    check(exp_q.size() == 0, "R4 pulses seen", exp_q.size(), 0);
    check(irq_o == 1, "R6 flag set", irq_o, 1);
    check(tclk_o == 0, "R3 timer clock low when stopped", tclk_o, 0);
    rd(2'd3, v); repeat (10) @(negedge clk); rd(2'd3, v2);
    check(v == v2, "R3 count frozen", v2, v);
    rd(2'd0, v); check(v == 16'h8000, "R8 ctrl with flag", v, 16'h8000);

    // R6 clear semantics
    wr(2'd3, 16'h0000);
    @(negedge clk); check(irq_o == 1, "R6 write of 0 keeps flag", irq_o, 1);
    wr(2'd3, 16'h0001);
    @(negedge clk); check(irq_o == 0, "R6 clear by 1", irq_o, 0);

    // R7 input mode, R2/R4 timing with P=2, L=3
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0003);
    c0 = last_c0;
    while (cyc < c0 + 20) @(negedge clk);
    check(irq_o == 0, "R4 no reload before period", irq_o, 0);
    @(negedge clk);
    check(irq_o == 1, "R4 reload at P+1+2L(P+1)", irq_o, 1);
    while (tclk_o) @(negedge clk);
    while (!tclk_o) @(negedge clk);
    hi = 0; while (tclk_o) begin hi++; @(negedge clk); end
    lo = 0; while (!tclk_o) begin lo++; @(negedge clk); end
    check(hi == 3, "R2 high time", hi, 3);
    check(lo == 3, "R2 low time", lo, 3);
    wr(2'd0, 16'h0000);
    check(tmo_o == 0 && exp_q.size() == 0, "R7 input mode no pulse", tmo_o, 0);

    // R6 enable clear: pulses still appear, flag stays low
    wr(2'd3, 16'h0001);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0005);
    c0 = last_c0;
    expect_pulses(c0, 0, 2, 3);
    repeat (19) @(negedge clk);
    wr(2'd0, 16'h0000);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 pulses with irq disabled", exp_q.size(), 0);
    check(irq_o == 0, "R6 disabled keeps flag low", irq_o, 0);

    // R5 load write while running does not touch count; R3 step
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd255);
    wr(2'd0, 16'h0001);
    c0 = last_c0;
    wr(2'd1, 16'd100);
    rd(2'd3, v); check(v == 9, "R5 running write ignored", v, 9);
    rd(2'd1, v); check(v == 100, "R8 new load stored", v, 100);
    while (cyc < c0 + 262) @(negedge clk);
    rd(2'd3, v); check(v == 8, "R3 one step per timer edge", v, 8);
    wr(2'd0, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule